// File: doc/BRIEF.md
# ADC Multi-Channel Scan Sequencer

This block sequences one analog-to-digital converter through a one-shot scan of a four-channel group. Software sets up a control/status register with a start bit, a mode bit, a two-bit field naming the highest channel to scan, an interrupt enable and a completion flag. A scan can be launched by a register write or by a pulse on an external trigger pin. The sequencer then converts channels from 0 up to the selected channel, one after another. It hands each request to a converter core through a start/done/result handshake and files every result in a data register that belongs to that channel.

When the last selected channel has been converted, the block sets the completion flag, drops the start bit by itself and goes quiet. An interrupt line follows the flag while interrupts are enabled. Software can abort a scan at any time by writing the start bit to 0. The completion flag is acknowledged with a read that sees it set, followed by a write of 0.

Register layout: address 0 is the control/status register, with bit 0 the start bit, bit 1 the mode bit, bits 3:2 the highest channel, bit 4 the interrupt enable and bit 7 the completion flag. All other bits read as 0. Addresses 1 to 4 hold the results of channels 0 to 3, zero-extended to 16 bits. All other addresses read as 0.

Top module: `adc_scan_top`

## Requirements
- R1: After reset, the control/status register reads 0, all four result registers read 0, the interrupt line is low and no converter start is issued.
- R2: When the start bit becomes 1, the first converter start, a one-cycle pulse on the start output, names channel 0. Each further start names the next higher channel and is issued in the cycle right after the previous converter done is accepted.
- R3: A scan with the highest-channel field (bits 3:2) at value k issues exactly k+1 converter starts, for channels 0 to k.
- R4: The result delivered with the converter done for channel c is stored in the register at address c+1. Result registers of channels outside the scan keep their values.
- R5: After the last selected channel has been converted, the completion flag (bit 7) reads 1, the start bit (bit 0) reads 0 and no further converter start is issued.
- R6: The interrupt line is high exactly while the completion flag and the interrupt enable (bit 4) are both 1, and it stays high until the flag is cleared.
- R7: Writing 0 to the start bit during a scan stops it at once. No further start is issued, a converter done that arrives later is not stored, and the completion flag is not set.
- R8: A write with bit 7 at 0 clears the completion flag only if a read of address 0 has returned the flag as 1 since it was last set. Without such a read the write leaves the flag at 1. Writing 1 to bit 7 never changes the flag.
- R9: A one-cycle external trigger pulse starts a scan when none is running. A trigger pulse during a scan has no effect: no restart and no extra conversions.
- R10: A single write may change the mode, the highest-channel field and the interrupt enable while also setting the start bit. The scan it starts uses the newly written values.
- R11: If a flag-clearing write lands in the same cycle as the completion of a scan, the completion flag ends at 1 and the start bit ends at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms the flag clear) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| ext_trig | input | 1 | External start pulse |
| conv_start | output | 1 | One-cycle request to the converter core |
| conv_ch | output | 2 | Channel of the current request |
| conv_done | input | 1 | One-cycle completion from the converter core |
| conv_result | input | 12 | Conversion result, valid with conv_done |
| irq | output | 1 | Interrupt request |

## Verification
The collision that matters is the end of a scan meeting a software write of 0 to the completion flag, with the flag already set and armed from an earlier scan. The bench arms the flag with a read, starts a second scan without clearing it, watches for the cycle in which the converter done of the last channel is high, and drives the clearing write in that same cycle. It then expects the flag at 1, the start bit at 0 and the interrupt still high. It also checks that the arming was used up, since a second write of 0 made without a new read leaves the flag set.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    localparam int NCH    = 4;
    localparam int CH_W   = $clog2(NCH);
    localparam int BUS_W  = 16;
    localparam int ADDR_W = 3;

    // control/status bit positions at address 0
    localparam int B_GO     = 0;
    localparam int B_MODE   = 1;
    localparam int B_SEL_LO = 2;
    localparam int B_IE     = 4;
    localparam int B_DONE   = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_st_t;

    typedef struct packed {
        logic            done;
        logic            ie;
        logic [CH_W-1:0] sel;
        logic            mode;
        logic            go;
    } ctl_t;

    function automatic logic [BUS_W-1:0] pack_ctl(input ctl_t c);
        logic [BUS_W-1:0] v;
        v                     = '0;
        v[B_GO]               = c.go;
        v[B_MODE]             = c.mode;
        v[B_SEL_LO +: CH_W]   = c.sel;
        v[B_IE]               = c.ie;
        v[B_DONE]             = c.done;
        return v;
    endfunction
endpackage

// File: rtl/adc_scan_csr.sv
module adc_scan_csr
    import adc_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctl,
    input  logic             rd_ctl,
    input  logic [BUS_W-1:0] wdata,
    input  logic             ext_trig,
    input  logic             fin,
    output ctl_t             ctl,
    output logic             armed,
    output logic             start_evt,
    output logic             halt
);
    logic go_n;
    logic clr_ok;
    logic wdata_unused;

    assign wdata_unused = ^wdata;

    // completion wins over any write; a trigger only acts when nothing is written
    always_comb begin
        go_n = ctl.go;
        if (fin)
            go_n = 1'b0;
        else if (wr_ctl)
            go_n = wdata[B_GO];
        else if (ext_trig)
            go_n = 1'b1;
    end

    assign start_evt = !ctl.go && go_n;
    assign halt      = ctl.go && wr_ctl && !wdata[B_GO];
    assign clr_ok    = wr_ctl && !wdata[B_DONE] && armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl   <= '0;
            armed <= 1'b0;
        end else begin
            ctl.go <= go_n;
            if (wr_ctl) begin
                ctl.mode <= wdata[B_MODE];
                ctl.sel  <= wdata[B_SEL_LO +: CH_W];
                ctl.ie   <= wdata[B_IE];
            end
            if (fin) begin
                ctl.done <= 1'b1;
                armed    <= 1'b0;
            end else if (clr_ok) begin
                ctl.done <= 1'b0;
                armed    <= 1'b0;
            end else if (rd_ctl && ctl.done) begin
                armed    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
    import adc_scan_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start_evt,
    input  logic            halt,
    input  logic            conv_done,
    input  logic [CH_W-1:0] sel,
    output logic            conv_start,
    output logic [CH_W-1:0] cur_ch,
    output logic            res_we,
    output logic            fin
);
    seq_st_t state;
    logic    last;

    assign last       = (cur_ch >= sel);
    assign conv_start = (state == ST_ISSUE);
    assign res_we     = (state == ST_WAIT) && conv_done;
    assign fin        = res_we && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cur_ch <= '0;
        end else if (start_evt) begin
            state  <= ST_ISSUE;
            cur_ch <= '0;
        end else if (res_we) begin
            if (last || halt) begin
                state <= ST_IDLE;
            end else begin
                state  <= ST_ISSUE;
                cur_ch <= cur_ch + 1'b1;
            end
        end else if (halt) begin
            state <= ST_IDLE;
        end else if (state == ST_ISSUE) begin
            state <= ST_WAIT;
        end
    end
endmodule

// File: rtl/adc_scan_bank.sv
module adc_scan_bank
    import adc_scan_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [CH_W-1:0]            wch,
    input  logic [RES_W-1:0]           wval,
    output logic [NCH-1:0][RES_W-1:0]  regs
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)
                regs[c] <= '0;
            else if (we && (wch == CH_W'(c)))
                regs[c] <= wval;
        end
    end
endmodule

// File: rtl/adc_scan_top.sv
module adc_scan_top
    import adc_scan_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              ext_trig,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_ch,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] LAST_RES = ADDR_W'(NCH);

    ctl_t                       ctl_q;
    logic                       armed;
    logic                       start_evt;
    logic                       halt;
    logic                       fin;
    logic                       res_we;
    logic                       wr_ctl;
    logic                       rd_ctl;
    logic [NCH-1:0][RES_W-1:0]  res_q;

    assign wr_ctl = bus_wr && (bus_addr == '0);
    assign rd_ctl = bus_rd && (bus_addr == '0);

    adc_scan_csr u_csr (
        .clk       (clk),
        .rst       (rst),
        .wr_ctl    (wr_ctl),
        .rd_ctl    (rd_ctl),
        .wdata     (bus_wdata),
        .ext_trig  (ext_trig),
        .fin       (fin),
        .ctl       (ctl_q),
        .armed     (armed),
        .start_evt (start_evt),
        .halt      (halt)
    );

    adc_scan_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_evt  (start_evt),
        .halt       (halt),
        .conv_done  (conv_done),
        .sel        (ctl_q.sel),
        .conv_start (conv_start),
        .cur_ch     (conv_ch),
        .res_we     (res_we),
        .fin        (fin)
    );

    adc_scan_bank #(.RES_W(RES_W)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .we   (res_we),
        .wch  (conv_ch),
        .wval (conv_result),
        .regs (res_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0)
            bus_rdata = pack_ctl(ctl_q);
        else if (bus_addr <= LAST_RES)
            bus_rdata[RES_W-1:0] = res_q[CH_W'(bus_addr - 1'b1)];
    end

    assign irq = ctl_q.done && ctl_q.ie;
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk
    import adc_scan_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input ctl_t              ctl,
    input logic              armed,
    input logic              fin,
    input logic              res_we,
    input logic              irq,
    input logic              conv_start,
    input logic [CH_W-1:0]   conv_ch,
    input logic              ext_trig,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr
);
    // R2: a newly raised start bit is met by a request for channel 0
    p_first_ch0_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.go) |-> (conv_start && conv_ch == '0));

    // R2: requests are single-cycle pulses
    p_one_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R5: completion leaves the flag set and the start bit cleared
    p_fin_state_r5: assert property (@(posedge clk) disable iff (rst)
        fin |=> (!ctl.go && ctl.done));

    // R6: interrupt holds unless the control register is written
    p_irq_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (irq && !(bus_wr && bus_addr == '0)) |=> irq);

    // R7: no result is stored while no scan is running
    p_no_store_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !ctl.go |-> !res_we);

    // R8: the flag only falls after it was armed by a read
    p_clear_armed_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.done) |-> $past(armed));

    // R9: a trigger during a scan never restarts it
    p_trig_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (ctl.go && ext_trig) |=> !(conv_start && conv_ch == '0));
endmodule

bind adc_scan_top adc_scan_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl_q),
    .armed      (armed),
    .fin        (fin),
    .res_we     (res_we),
    .irq        (irq),
    .conv_start (conv_start),
    .conv_ch    (conv_ch),
    .ext_trig   (ext_trig),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr)
);

// File: tb/adc_scan_top_tb_top.sv
module adc_scan_top_tb_top;
    // default time unit of 1 ps: 4000 ps period gives 250 MHz
    localparam int HALF = 2000;
    localparam int SKEW = 500;
    localparam int RW   = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_trig = 1'b0;
    logic        conv_start;
    logic [1:0]  conv_ch;
    logic        conv_done = 1'b0;
    logic [RW-1:0] conv_result = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // converter model state
    logic [RW-1:0] conv_val [4];
    logic [RW-1:0] exp_res  [4];
    int  lat = 2;
    int  log_ch [16];
    int  log_n = 0;
    bit  conv_busy = 0;

    always #HALF clk = ~clk;

    adc_scan_top dut_i (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .ext_trig    (ext_trig),
        .conv_start  (conv_start),
        .conv_ch     (conv_ch),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .irq         (irq)
    );

    // converter core model: answers each request after lat cycles
    initial begin
        int c;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            conv_busy = 0;
            if (conv_start) begin
                c = int'(conv_ch);
                conv_busy = 1;
                if (log_n < 16) log_ch[log_n] = c;
                log_n++;
                repeat (lat) @(negedge clk);
                conv_done   = 1'b1;
                conv_result = conv_val[c];
            end
        end
    end

    function automatic logic [15:0] cfg(input bit go, input bit mode, input int sel,
                                        input bit ie, input bit keep_done);
        logic [15:0] v;
        v = '0;
        v[0] = go; v[1] = mode; v[3:2] = 2'(sel); v[4] = ie; v[7] = keep_done;
        return v;
    endfunction

    function automatic int exp_csr(input bit go, input bit mode, input int sel,
                                   input bit ie, input bit done);
        return int'({8'd0, done, 2'b00, ie, 2'(sel), mode, go});
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin @(negedge clk); #SKEW; end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        tick(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        bus_rd = 1'b1; bus_addr = 3'(a);
        #SKEW;
        v = int'(bus_rdata);
        @(negedge clk); #SKEW;
        bus_rd = 1'b0;
    endtask

    task automatic pulse_trig();
        ext_trig = 1'b1;
        tick(1);
        ext_trig = 1'b0;
    endtask

    task automatic new_vals();
        for (int c = 0; c < 4; c++) conv_val[c] = RW'($urandom_range(0, 4095));
    endtask

    task automatic check_results(input string req);
        int v;
        for (int c = 0; c < 4; c++) begin
            rd(c + 1, v);
            chk(v == int'(exp_res[c]), req, "result register", v, int'(exp_res[c]));
        end
    endtask

    task automatic check_order(input int sel);
        chk(log_n == sel + 1, "R3", "conversion count", log_n, sel + 1);
        for (int i = 0; i < log_n && i < 16; i++)
            chk(log_ch[i] == i, "R2", "channel order", log_ch[i], i);
    endtask

    // start a scan, let it finish, check order and results; no read of address 0
    task automatic start_wait(input int sel, input bit ie, input bit mode, input bit use_trig);
        new_vals();
        lat = $urandom_range(1, 4);
        log_n = 0;
        if (use_trig) begin
            wr(0, cfg(0, mode, sel, ie, 1));
            pulse_trig();
        end else begin
            wr(0, cfg(1, mode, sel, ie, 1));
        end
        tick((sel + 1) * (lat + 3) + 10);
        check_order(sel);
        for (int c = 0; c <= sel; c++) exp_res[c] = conv_val[c];
        check_results("R4");
        chk(irq == ie, "R6", "irq after scan", int'(irq), int'(ie));
    endtask

    task automatic read_then_clear(input int sel, input bit ie, input bit mode);
        int v;
        rd(0, v);
        chk(v == exp_csr(0, mode, sel, ie, 1), "R5", "csr after scan", v, exp_csr(0, mode, sel, ie, 1));
        wr(0, cfg(0, mode, sel, ie, 0));
        rd(0, v);
        chk(v == exp_csr(0, mode, sel, ie, 0), "R8", "csr after armed clear", v, exp_csr(0, mode, sel, ie, 0));
        chk(irq == 1'b0, "R6", "irq after clear", int'(irq), 0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int v;
        int sel;
        bit ie, mode, trg, hit;
        void'($urandom(32'd20240611));
        for (int c = 0; c < 4; c++) begin exp_res[c] = '0; conv_val[c] = '0; end

        tick(3);
        rst = 1'b0;
        tick(1);

        // R1: reset state
        rd(0, v);
        chk(v == 0, "R1", "csr after reset", v, 0);
        chk(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);
        chk(conv_start == 1'b0, "R1", "conv_start after reset", int'(conv_start), 0);
        check_results("R1");

        // directed: every channel field value, software start
        for (int s = 0; s < 4; s++) begin
            start_wait(s, 1, 1, 0);
            read_then_clear(s, 1, 1);
        end

        // R8: write of 0 without a prior read keeps the flag
        start_wait(2, 1, 0, 0);
        wr(0, cfg(0, 0, 2, 1, 0));
        chk(irq == 1'b1, "R6", "irq held after unarmed write", int'(irq), 1);
        rd(0, v);
        chk(v == exp_csr(0, 0, 2, 1, 1), "R8", "unarmed clear ignored", v, exp_csr(0, 0, 2, 1, 1));
        wr(0, cfg(0, 0, 2, 1, 1));
        rd(0, v);
        chk(v == exp_csr(0, 0, 2, 1, 1), "R8", "writing 1 to flag", v, exp_csr(0, 0, 2, 1, 1));
        wr(0, cfg(0, 0, 2, 1, 0));
        rd(0, v);
        chk(v == exp_csr(0, 0, 2, 1, 0), "R8", "armed clear", v, exp_csr(0, 0, 2, 1, 0));

        // R9: external trigger starts; a trigger mid-scan is ignored
        start_wait(1, 0, 1, 1);
        read_then_clear(1, 0, 1);
        new_vals();
        lat = 4; log_n = 0;
        wr(0, cfg(1, 1, 3, 0, 1));
        tick(3);
        pulse_trig();
        tick(8);
        pulse_trig();
        tick(40);
        chk(log_n == 4, "R9", "conversions with mid-scan trigger", log_n, 4);
        check_order(3);
        for (int c = 0; c < 4; c++) exp_res[c] = conv_val[c];
        check_results("R4");
        read_then_clear(3, 0, 1);

        // R7: halt during channel 1, late done discarded
        new_vals();
        conv_val[1] = exp_res[1] ^ RW'(1);
        lat = 6; log_n = 0;
        wr(0, cfg(1, 1, 3, 1, 1));
        hit = 0;
        for (int i = 0; i < 100 && !hit; i++) begin
            if (log_n >= 2) hit = 1; else tick(1);
        end
        wr(0, cfg(0, 1, 3, 1, 1));
        tick(20);
        chk(log_n == 2, "R7", "starts after halt", log_n, 2);
        exp_res[0] = conv_val[0];
        check_results("R7");
        rd(0, v);
        chk(v == exp_csr(0, 1, 3, 1, 0), "R7", "csr after halt", v, exp_csr(0, 1, 3, 1, 0));
        chk(irq == 1'b0, "R7", "irq after halt", int'(irq), 0);

        // R10: new field and start in one write, restart from channel 0
        new_vals();
        lat = 2; log_n = 0;
        wr(0, cfg(1, 0, 1, 1, 1));
        tick(20);
        chk(log_n == 2, "R10", "count with new field", log_n, 2);
        check_order(1);
        exp_res[0] = conv_val[0]; exp_res[1] = conv_val[1];
        check_results("R10");
        read_then_clear(1, 1, 0);

        // R11: clearing write in the completion cycle
        start_wait(0, 1, 1, 0);
        rd(0, v);
        chk(v == exp_csr(0, 1, 0, 1, 1), "R5", "csr before collision", v, exp_csr(0, 1, 0, 1, 1));
        new_vals();
        lat = 3; log_n = 0;
        wr(0, cfg(1, 1, 2, 1, 1));
        hit = 0;
        for (int i = 0; i < 100 && !hit; i++) begin
            tick(1);
            if (conv_done && log_n == 3) hit = 1;
        end
        chk(hit, "R11", "reached last done", int'(hit), 1);
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = cfg(1, 1, 2, 1, 0);
        tick(1);
        bus_wr = 1'b0;
        tick(1);
        for (int c = 0; c < 3; c++) exp_res[c] = conv_val[c];
        check_results("R4");
        chk(irq == 1'b1, "R11", "irq after collision", int'(irq), 1);
        wr(0, cfg(0, 1, 2, 1, 0));
        rd(0, v);
        chk(v == exp_csr(0, 1, 2, 1, 1), "R11", "flag kept, start cleared", v, exp_csr(0, 1, 2, 1, 1));
        wr(0, cfg(0, 1, 2, 1, 0));
        rd(0, v);
        chk(v == exp_csr(0, 1, 2, 1, 0), "R8", "clear after re-read", v, exp_csr(0, 1, 2, 1, 0));

        // constrained random scans
        for (int it = 0; it < 24; it++) begin
            sel  = $urandom_range(0, 3);
            ie   = 1'($urandom_range(0, 1));
            mode = 1'($urandom_range(0, 1));
            trg  = 1'($urandom_range(0, 1));
            start_wait(sel, ie, mode, trg);
            read_then_clear(sel, ie, mode);
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule